// File: doc/BRIEF.md
# Burst Address Generator with Selectable Beat Order

This block supplies the address for a four-beat burst access to a synchronous memory. When an access begins, one of two active-low address strobes captures a full external address. After that, the two least significant bits step through the burst under control of an active-low advance input. The upper bits stay where they were loaded until the next load.

The beat order is chosen at run time by a single input. In linear order each step adds one to the starting pair, modulo four. In interleaved order the n-th beat is the starting pair XOR n. The order input is applied combinationally to the registered start value and beat count, so it can change between beats. A registered flag is high in the cycle that follows a load, which marks a fresh address. Loads may arrive on every cycle.

The two strobes differ in how they are gated and in priority. The processor strobe counts only while the chip enable is high, and it takes priority when it counts. The controller strobe loads only while the processor strobe is high.

Top module: `burst_addr_gen`

## Requirements
- R1: When `ads_cpu_n` is 0 and `sel` is 1 at a clock edge, the next cycle shows `addr_out` equal to that edge's `addr_in` and `loaded` equal to 1.
- R2: When `ads_cpu_n` is 0 and `sel` is 0, no load occurs at that edge and `loaded` is 0 in the next cycle. This holds even if `ads_ctl_n` is also 0. In that case the cycle behaves as a non-load cycle, so it advances or holds according to `adv_n`.
- R3: When `ads_cpu_n` is 1 and `ads_ctl_n` is 0, the edge loads `addr_in` whatever the value of `sel`, and `loaded` is 1 in the next cycle.
- R4: With `order_il` = 0, the low two bits of `addr_out` equal the loaded start pair plus the beat count, modulo 4.
- R5: With `order_il` = 1, the low two bits of `addr_out` equal the loaded start pair XOR the beat count.
- R6: The beat count is 0 after a load. Each non-load edge with `adv_n` = 0 adds 1 modulo 4, so the fifth beat returns to the start pair.
- R7: A non-load edge with `adv_n` = 1 leaves the beat count unchanged (suspend), and `loaded` is 0 in the next cycle.
- R8: Bits `addr_out[AW-1:2]` change only at a load edge.
- R9: Loads on consecutive edges are each taken in full, with `loaded` staying at 1.
- R10: A synchronous active-high `rst` clears the start pair, the beat count and the upper bits, and drops `loaded` to 0. With `order_il` = 0, `addr_out` then reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ads_cpu_n | input | 1 | Processor address strobe, active low, gated by `sel` |
| ads_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance enable, active low |
| sel | input | 1 | Chip enable that qualifies the processor strobe, active high |
| order_il | input | 1 | Beat order: 0 linear, 1 interleaved |
| addr_in | input | AW | External address captured on a load |
| addr_out | output | AW | Current burst address |
| loaded | output | 1 | High in the cycle after a load |

## Verification
The assertions assume that every control and address input is a known 0 or 1 at each rising edge, and that `rst` is held high through at least one edge before any check starts. The bench drives all inputs between edges with binary values only. It holds reset for three edges and compares the outputs half a period after each edge. It keeps `order_il` fixed within a compared cycle, so the combinational order mux is checked against the same value the reference model uses.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ads_cpu_n,
  input  logic          ads_ctl_n,
  input  logic          adv_n,
  input  logic          sel,
  input  logic          order_il,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          loaded
);
  localparam int UW = AW - 2;

  logic [UW-1:0] hi_q;
  logic [1:0]    base_q, beat_q, lo;
  logic          loaded_q;

  wire cpu_take = !ads_cpu_n && sel;
  wire ctl_take = ads_cpu_n && !ads_ctl_n;
  wire take     = cpu_take || ctl_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      base_q   <= '0;
      beat_q   <= '0;
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= take;
      if (take) begin
        hi_q   <= addr_in[AW-1:2];
        base_q <= addr_in[1:0];
        beat_q <= '0;
      end else if (!adv_n) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign lo       = order_il ? (base_q ^ beat_q) : (base_q + beat_q);
  assign addr_out = {hi_q, lo};
  assign loaded   = loaded_q;

  assert_cpu_load_R1: assert property (@(posedge clk) disable iff (rst)
    cpu_take |=> loaded && addr_out == $past(addr_in));
  assert_cpu_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (!ads_cpu_n && !sel) |=> !loaded && $stable(hi_q) && $stable(base_q));
  assert_ctl_load_R3: assert property (@(posedge clk) disable iff (rst)
    ctl_take |=> loaded && addr_out == $past(addr_in));
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!take && !adv_n) |=> beat_q == 2'($past(beat_q) + 2'd1));
  assert_suspend_R7: assert property (@(posedge clk) disable iff (rst)
    (!take && adv_n) |=> $stable(beat_q) && !loaded);
  assert_upper_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(addr_out[AW-1:2]));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 18;
  logic clk = 0, rst = 1;
  logic ads_cpu_n = 1, ads_ctl_n = 1, adv_n = 1, sel = 0, order_il = 0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic loaded;

  int n_chk = 0, n_bad = 0;
  logic [AW-3:0] r_hi = '0;
  logic [1:0] r_base = '0, r_beat = '0;
  logic r_ld = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW)) dut (.clk(clk), .rst(rst), .ads_cpu_n(ads_cpu_n),
    .ads_ctl_n(ads_ctl_n), .adv_n(adv_n), .sel(sel), .order_il(order_il),
    .addr_in(addr_in), .addr_out(addr_out), .loaded(loaded));

  function automatic logic [AW-1:0] expect_addr();
    logic [1:0] lo;
    lo = order_il ? (r_base ^ r_beat) : 2'((r_base + r_beat) % 4);
    return {r_hi, lo};
  endfunction

  task automatic check(string rq);
    n_chk++;
    if (addr_out !== expect_addr() || loaded !== r_ld) begin
      n_bad++;
      $display("FAIL %s: addr=%h loaded=%b expected addr=%h loaded=%b",
               rq, addr_out, loaded, expect_addr(), r_ld);
    end
  endtask

  task automatic cyc(string rq, logic cpu, logic ctl, logic adv, logic s,
                     logic ord, logic [AW-1:0] a);
    bit tk;
    ads_cpu_n = cpu; ads_ctl_n = ctl; adv_n = adv; sel = s; order_il = ord; addr_in = a;
    @(posedge clk);
    tk = (!cpu && s) || (cpu && !ctl);
    r_ld = tk;
    if (tk) begin r_hi = a[AW-1:2]; r_base = a[1:0]; r_beat = 0; end
    else if (!adv) r_beat = r_beat + 2'd1;
    @(negedge clk);
    check(rq);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset");
    rst = 0;
    for (int o = 0; o < 2; o++)
      for (int s0 = 0; s0 < 4; s0++) begin
        cyc("R1 cpu load", 0, 1, 1, 1, o[0], {16'h1A5 + 16'(s0*7), s0[1:0]});
        cyc(o ? "R5 interleave" : "R4 linear", 1, 1, 0, 0, o[0], '0);
        cyc("R7 suspend", 1, 1, 1, 0, o[0], '1);
        cyc("R7 suspend", 1, 1, 1, 1, o[0], '1);
        cyc(o ? "R5 interleave" : "R4 linear", 1, 1, 0, 1, o[0], '0);
        cyc("R6 step", 1, 1, 0, 0, o[0], '0);
        cyc("R6 wrap", 1, 1, 0, 0, o[0], '0);
        cyc("R8 upper hold", 1, 1, 0, 0, o[0], 18'h2AAAA);
      end
    cyc("R3 ctl load", 1, 0, 1, 0, 0, 18'h3C0F2);
    cyc("R3 ctl load sel", 1, 0, 0, 1, 1, 18'h00C01);
    cyc("R2 ignored", 0, 1, 0, 0, 0, 18'h3FFFF);
    cyc("R2 ignored", 0, 0, 1, 0, 1, 18'h12345);
    cyc("R2 ignored adv", 0, 0, 0, 0, 0, 18'h12345);
    for (int k = 0; k < 6; k++)
      cyc("R9 back to back", k[0], 0, 0, 1, k[1], 18'(k * 18'h0ABCD + 3));
    cyc("R1 cpu priority", 0, 0, 0, 1, 0, 18'h04446);
    cyc("R8 upper hold", 1, 1, 0, 1, 1, 18'h3FFFC);
    rst = 1;
    ads_cpu_n = 1; ads_ctl_n = 1; order_il = 0;
    @(posedge clk);
    r_hi = '0; r_base = '0; r_beat = '0; r_ld = 0;
    @(negedge clk);
    check("R10 reset midrun");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule